// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block stretches processor bus cycles by holding a ready line low for a programmed number of clocks. Each bus cycle is announced by a one-clock start strobe together with a cycle-kind code. The block turns that code and the contents of a wait-control register into a wait count, loads a down-counter, and keeps `ready` low until the counter drains. Memory, I/O, opcode-fetch, interrupt-vector, interrupt-acknowledge and return-from-interrupt cycles each take their own count. Acknowledge and return-from-interrupt share one 2-bit field that gives them paired, unequal chained waits.

Software reaches the configuration through two byte ports. A write to the select port chooses a register number. Data-port writes and the combinational read-back then act on the selected register. Number 0 is the wait-control register. Number 3 is a miscellaneous control register whose bits drive two chip-select enables, a reset-output enable and a clock-divide select. Every other number reads as zero and ignores writes. After reset the wait-control register holds its slowest setting, so slow devices work before software configures the block.

Top module: `bus_wait_sequencer`

## Requirements
- R1: The select port stores an 8-bit register number. The data port reads and writes register 0 (wait control) or register 3 (misc control). Any other number reads as 0x00, and a data write to it changes no register.
- R2: After reset the select register is 0, wait control is 0xFF, misc control is 0x00, and `ready` is 1.
- R3: An I/O cycle (kind code 1) waits 2 × wait-control bits [1:0] clocks, giving 0, 2, 4 or 6.
- R4: A memory cycle (kind code 0) waits the value of wait-control bits [3:2] clocks, giving 0 to 3.
- R5: An opcode-fetch cycle (kind code 2) waits the memory count plus wait-control bit 4.
- R6: An interrupt-vector read (kind code 3) waits wait-control bit 5 clocks (0 or 1).
- R7: Wait-control bits [7:6] set the interrupt-acknowledge (kind code 4) and return-from-interrupt (kind code 5) waits as the pairs 00→0/0, 01→2/0, 10→4/2 and 11→6/4. Kind codes 6 and 7 wait 0 clocks.
- R8: A start strobe sampled while `ready` is 1 loads a count N. `ready` is then low for exactly N clocks, beginning in the cycle after the strobe edge. When N is 0, `ready` never goes low.
- R9: A start strobe that arrives while `ready` is low is ignored, and the wait in progress keeps its length.
- R10: Misc-control bit 0 drives `cs0_en`, bit 1 drives `cs1_en`, bit 3 set drives `rst_out_en` low, and bit 4 drives `clk_div1`. Bits 2, 5, 6 and 7 are not stored and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Write strobe for the register-select port |
| sel_wdata | input | 8 | Register number to select |
| cfg_wr | input | 1 | Write strobe for the data port |
| cfg_wdata | input | 8 | Data to write to the selected register |
| cfg_rdata | output | 8 | Contents of the selected register |
| cyc_start | input | 1 | One-clock strobe marking the start of a bus cycle |
| cyc_kind | input | 3 | Cycle kind: 0 mem, 1 I/O, 2 fetch, 3 vector, 4 ack, 5 reti |
| ready | output | 1 | High when the bus may proceed, low while waiting |
| cs0_en | output | 1 | Chip-select 0 enable |
| cs1_en | output | 1 | Chip-select 1 enable |
| rst_out_en | output | 1 | Reset-output enable |
| clk_div1 | output | 1 | 1 selects divide-by-one, 0 selects divide-by-two |

## Verification
A corrupted wait-control register or a wrong decode lane shows up as a `ready` low pulse of the wrong length on the very next cycle of the affected kind. The bench therefore sweeps all 256 wait-control values against all eight kind codes and measures every pulse. A down-counter that skips or stalls shows up within the same pulse, and the checker sees it at the edge where it happens. A select-decode fault that lets a write land in the wrong register shows up on the next read-back or on the misc outputs one clock later.

// File: rtl/bws_pkg.sv
package bws_pkg;

    localparam int REG_W = 8;

    typedef enum logic [2:0] {
        CYC_MEM   = 3'd0,
        CYC_IO    = 3'd1,
        CYC_FETCH = 3'd2,
        CYC_VEC   = 3'd3,
        CYC_ACK   = 3'd4,
        CYC_RETI  = 3'd5,
        CYC_RSV6  = 3'd6,
        CYC_RSV7  = 3'd7
    } cyc_kind_e;

    localparam logic [REG_W-1:0] SEL_WAIT  = 8'd0;
    localparam logic [REG_W-1:0] SEL_MISC  = 8'd3;
    localparam logic [REG_W-1:0] MISC_MASK = 8'h1B;

    typedef struct packed {
        logic [REG_W-1:0] ptr;
        logic [REG_W-1:0] wcr;
        logic [REG_W-1:0] mcr;
    } regs_t;

endpackage

// File: rtl/bws_wait_decode.sv
module bws_wait_decode
    import bws_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [REG_W-1:0] wcr,
    input  logic [2:0]       kind,
    output logic [CNT_W-1:0] waits
);

    logic [3:0] io_w;
    logic [3:0] mem_w;
    logic [3:0] fetch_w;
    logic [3:0] vec_w;
    logic [3:0] ack_w;
    logic [3:0] reti_w;
    logic [3:0] sel_w;

    always_comb begin
        io_w    = {1'b0, wcr[1:0], 1'b0};
        mem_w   = {2'b00, wcr[3:2]};
        fetch_w = mem_w + {3'b000, wcr[4]};
        vec_w   = {3'b000, wcr[5]};
        ack_w   = {1'b0, wcr[7:6], 1'b0};
        reti_w  = (wcr[7:6] == 2'b00) ? 4'd0 : (ack_w - 4'd2);
        case (cyc_kind_e'(kind))
            CYC_MEM:   sel_w = mem_w;
            CYC_IO:    sel_w = io_w;
            CYC_FETCH: sel_w = fetch_w;
            CYC_VEC:   sel_w = vec_w;
            CYC_ACK:   sel_w = ack_w;
            CYC_RETI:  sel_w = reti_w;
            default:   sel_w = 4'd0;
        endcase
        waits = CNT_W'(sel_w);
    end

endmodule

// File: rtl/bws_regs.sv
module bws_regs
    import bws_pkg::*;
#(
    parameter logic [REG_W-1:0] WCR_RESET = 8'hFF,
    parameter logic [REG_W-1:0] MCR_RESET = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [REG_W-1:0] sel_wdata,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] ptr_q,
    output logic [REG_W-1:0] wcr_q,
    output logic [REG_W-1:0] mcr_q,
    output logic [REG_W-1:0] rdata
);

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sel_wr) begin
            r_d.ptr = sel_wdata;
        end
        if (cfg_wr) begin
            if (r_q.ptr == SEL_WAIT) begin
                r_d.wcr = cfg_wdata;
            end else if (r_q.ptr == SEL_MISC) begin
                r_d.mcr = cfg_wdata & MISC_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ptr: '0, wcr: WCR_RESET, mcr: MCR_RESET & MISC_MASK};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (r_q.ptr == SEL_WAIT) begin
            rdata = r_q.wcr;
        end else if (r_q.ptr == SEL_MISC) begin
            rdata = r_q.mcr;
        end else begin
            rdata = '0;
        end
    end

    assign ptr_q = r_q.ptr;
    assign wcr_q = r_q.wcr;
    assign mcr_q = r_q.mcr;

endmodule

// File: rtl/bws_wait_counter.sv
module bws_wait_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ready
);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end else if (start) begin
            cnt_d = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ready = (cnt_q == '0);

endmodule

// File: rtl/bus_wait_sequencer.sv
module bus_wait_sequencer
    import bws_pkg::*;
#(
    parameter logic [7:0] WCR_RESET = 8'hFF,
    parameter logic [7:0] MCR_RESET = 8'h00,
    parameter int         MAX_WAIT  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [7:0] sel_wdata,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       cyc_start,
    input  logic [2:0] cyc_kind,
    output logic       ready,
    output logic       cs0_en,
    output logic       cs1_en,
    output logic       rst_out_en,
    output logic       clk_div1
);

    localparam int CNT_W = $clog2(MAX_WAIT + 1);

    logic [REG_W-1:0] ptr_q;
    logic [REG_W-1:0] wcr_q;
    logic [REG_W-1:0] mcr_q;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_q;

    bws_regs #(
        .WCR_RESET (WCR_RESET),
        .MCR_RESET (MCR_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .ptr_q     (ptr_q),
        .wcr_q     (wcr_q),
        .mcr_q     (mcr_q),
        .rdata     (cfg_rdata)
    );

    bws_wait_decode #(
        .CNT_W (CNT_W)
    ) u_decode (
        .wcr   (wcr_q),
        .kind  (cyc_kind),
        .waits (load_val)
    );

    bws_wait_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cyc_start),
        .load_val (load_val),
        .cnt_q    (cnt_q),
        .ready    (ready)
    );

    assign cs0_en     = mcr_q[0];
    assign cs1_en     = mcr_q[1];
    assign rst_out_en = ~mcr_q[3];
    assign clk_div1   = mcr_q[4];

endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_start,
    input logic             ready,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] cnt_q,
    input logic             cfg_wr,
    input logic [7:0]       ptr_q,
    input logic [7:0]       wcr_q,
    input logic [7:0]       mcr_q
);

    assert_zero_no_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && ready && load_val == '0) |=> ready);

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && ready && load_val != '0) |=> (!ready && cnt_q == $past(load_val)));

    assert_busy_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_bad_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && ptr_q != 8'd0 && ptr_q != 8'd3) |=> ($stable(wcr_q) && $stable(mcr_q)));

    assert_misc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_wr && ptr_q == 8'd3)) |=> $stable(mcr_q));

    assert_misc_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mcr_q & 8'hE4) == 8'h00);

endmodule

bind bus_wait_sequencer bws_checker #(.CNT_W(CNT_W)) u_bws_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .ready     (ready),
    .load_val  (load_val),
    .cnt_q     (cnt_q),
    .cfg_wr    (cfg_wr),
    .ptr_q     (ptr_q),
    .wcr_q     (wcr_q),
    .mcr_q     (mcr_q)
);

// File: tb/test_bus_wait_sequencer.sv
module test_bus_wait_sequencer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 1'b0;
    logic [7:0] sel_wdata = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       cyc_start = 1'b0;
    logic [2:0] cyc_kind = '0;
    logic       ready;
    logic       cs0_en, cs1_en, rst_out_en, clk_div1;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_wait_sequencer i_bus_wait_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cyc_start  (cyc_start),
        .cyc_kind   (cyc_kind),
        .ready      (ready),
        .cs0_en     (cs0_en),
        .cs1_en     (cs1_en),
        .rst_out_en (rst_out_en),
        .clk_div1   (clk_div1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_waits(input int w, input int k);
        int chain;
        chain = (w >> 6) & 3;
        case (k)
            0: return (w >> 2) & 3;
            1: return 2 * (w & 3);
            2: return ((w >> 2) & 3) + ((w >> 4) & 1);
            3: return (w >> 5) & 1;
            4: return 2 * chain;
            5: return (chain == 0) ? 0 : 2 * chain - 2;
            default: return 0;
        endcase
    endfunction

    task automatic set_sel(input logic [7:0] v);
        @(negedge clk);
        sel_wr = 1'b1; sel_wdata = v;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic measure(input int k, output int n);
        @(negedge clk);
        cyc_start = 1'b1; cyc_kind = 3'(k);
        @(negedge clk);
        cyc_start = 1'b0;
        n = 0;
        while (!ready && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R8 actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        check(ready === 1'b1, "R2 ready", int'(ready), 1);
        check(cfg_rdata === 8'hFF, "R2 wait ctrl", int'(cfg_rdata), 255);
        check(cs0_en === 1'b0 && cs1_en === 1'b0, "R2 cs", int'({cs1_en, cs0_en}), 0);
        check(rst_out_en === 1'b1 && clk_div1 === 1'b0, "R2 misc", int'({rst_out_en, clk_div1}), 2);
        set_sel(8'd3);
        check(cfg_rdata === 8'h00, "R2 misc ctrl", int'(cfg_rdata), 0);

        // R1: unused select numbers read zero and ignore writes
        for (int p = 1; p < 12; p++) begin
            if (p != 3) begin
                set_sel(8'(p));
                check(cfg_rdata === 8'h00, "R1 read unused", int'(cfg_rdata), 0);
                write_cfg(8'h5A);
                check(cfg_rdata === 8'h00, "R1 read after write", int'(cfg_rdata), 0);
            end
        end
        set_sel(8'hFF);
        write_cfg(8'hFF);
        check(cfg_rdata === 8'h00, "R1 sel 255", int'(cfg_rdata), 0);
        check(cs0_en === 1'b0 && rst_out_en === 1'b1, "R1 misc untouched", int'({cs0_en, rst_out_en}), 1);
        set_sel(8'd0);
        check(cfg_rdata === 8'hFF, "R1 wait ctrl untouched", int'(cfg_rdata), 255);

        // R10: misc control bits
        set_sel(8'd3);
        write_cfg(8'hFF);
        check(cfg_rdata === 8'h1B, "R10 readback", int'(cfg_rdata), 27);
        check({cs0_en, cs1_en, rst_out_en, clk_div1} === 4'b1101, "R10 outputs ff",
              int'({cs0_en, cs1_en, rst_out_en, clk_div1}), 13);
        write_cfg(8'h11);
        check({cs0_en, cs1_en, rst_out_en, clk_div1} === 4'b1011, "R10 outputs 11",
              int'({cs0_en, cs1_en, rst_out_en, clk_div1}), 11);
        write_cfg(8'h0A);
        check({cs0_en, cs1_en, rst_out_en, clk_div1} === 4'b0100, "R10 outputs 0a",
              int'({cs0_en, cs1_en, rst_out_en, clk_div1}), 4);
        write_cfg(8'hE4);
        check(cfg_rdata === 8'h00, "R10 unstored bits", int'(cfg_rdata), 0);

        // R3 R4 R5 R6 R7 R8: full sweep
        set_sel(8'd0);
        for (int w = 0; w < 256; w++) begin
            write_cfg(8'(w));
            check(cfg_rdata === 8'(w), "R1 wait ctrl readback", int'(cfg_rdata), w);
            for (int k = 0; k < 8; k++) begin
                measure(k, n);
                case (k)
                    0: check(n == exp_waits(w, k), "R4 mem", n, exp_waits(w, k));
                    1: check(n == exp_waits(w, k), "R3 io", n, exp_waits(w, k));
                    2: check(n == exp_waits(w, k), "R5 fetch", n, exp_waits(w, k));
                    3: check(n == exp_waits(w, k), "R6 vector", n, exp_waits(w, k));
                    4, 5: check(n == exp_waits(w, k), "R7 chain", n, exp_waits(w, k));
                    default: check(n == 0, "R8 reserved kind zero", n, 0);
                endcase
            end
        end

        // R9: strobe during wait ignored
        write_cfg(8'h03);
        @(negedge clk);
        cyc_start = 1'b1; cyc_kind = 3'd1;
        @(negedge clk);
        cyc_kind = 3'd4;
        n = 0;
        while (!ready && n < 20) begin
            n++;
            @(negedge clk);
        end
        cyc_start = 1'b0;
        check(n == 6, "R9 busy strobe ignored", n, 6);
        @(negedge clk);
        check(ready === 1'b1, "R9 no reload", int'(ready), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule